// File: doc/BRIEF.md
# Dual-format control-pin serializer

This block owns three general-purpose control outputs. In direct mode each output simply follows a bit written by software. In serializer mode the same three outputs become a serial link. The link shifts out a start byte, a data byte and an end byte. It can use a two-line format (clock and data) or one of three three-line formats, which add an enable line.

The serial clock is produced by a fixed divider from the system (crystal-rate) clock. Each serial bit occupies one divider period. Data is launched when the clock falls and is held stable across the following rising edge. A start strobe begins a transfer. A busy flag covers the whole transfer, and a one-cycle done pulse marks its end. Configuration is written through a simple address/data write port.

Top module: `ctl_serializer`

## Requirements
- R1: The serial clock period is DIV (default 38) system cycles. In each bit period the clock is low for the first DIV/2 cycles and high for the rest.
- R2: When the serializer owns the outputs, output 1 carries the serial clock and output 0 carries the serial data.
- R3: Ownership bit (bit 0 at address 1) set to 0 makes outputs [2:0] equal the direct bits at address 0, bits [2:0]. Set to 1, the serializer drives them. A direct-bit write takes effect on the outputs in the cycle after it is captured, and has no effect on the outputs while the serializer owns them.
- R4: After reset, ownership is 0, the direct bits are 0, the outputs are 000, and busy and done are 0.
- R5: A transfer sends 24 bits MSB first: the start byte (address 2), then the data byte (address 3), then the end byte (address 4). Each bit is presented from the falling clock edge that opens its period.
- R6: Mode 00 (address 1, bits [2:1]) is the two-line format, and output 2 stays 0 throughout.
- R7: Mode 01 drives output 2 high for all 24 bit periods of the transfer.
- R8: Mode 10 drives output 2 high only during the first bit period.
- R9: Mode 11 drives output 2 high only during the last bit period.
- R10: When idle and owned, clock and data are high and output 2 is low. Busy rises in the cycle after the start strobe is captured and falls once the 24th period ends. Done is high for exactly that one following cycle.
- R11: A start strobe during a transfer is ignored. A mode write during a transfer only affects the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (crystal-rate) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 direct, 1 control, 2 start, 3 data, 4 end |
| wr_data | input | 8 | Register write data |
| start | input | 1 | Transfer start strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer completion |
| ctl_out | output | 3 | Control outputs: [0] data, [1] clock, [2] enable when owned |

## Verification
A start strobe captured at a clock edge makes busy high after that edge. From that point, output pattern number t (counted from 0) belongs to bit t/38, at divider phase t mod 38. The bench samples at every falling system-clock edge and compares against that arithmetic. Done and the idle pins are checked at t = 912, and the done pulse is checked to be gone one cycle later. Register writes are driven at a falling edge and captured at the next rising edge, so their effect on the outputs is checked at the falling edge after that.

// File: rtl/ser_pkg.sv
package ser_pkg;
   typedef enum logic [1:0] {
      MODE_2W      = 2'b00,
      MODE_3W_FULL = 2'b01,
      MODE_3W_HEAD = 2'b10,
      MODE_3W_TAIL = 2'b11
   } ser_mode_e;

   localparam logic [2:0] ADDR_DIRECT = 3'd0;
   localparam logic [2:0] ADDR_CTRL   = 3'd1;
   localparam logic [2:0] ADDR_HEAD   = 3'd2;
   localparam logic [2:0] ADDR_BODY   = 3'd3;
   localparam logic [2:0] ADDR_TAIL   = 3'd4;
endpackage

// File: rtl/ser_clkdiv.sv
module ser_clkdiv #(
   parameter int DIV = 38
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic period_end,
   output logic sclk_lvl
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);
   localparam logic [CW-1:0] HALF = CW'(DIV / 2);

   generate
      if (DIV < 4) begin : g_bad_div
         $error("ser_clkdiv: DIV must be at least 4");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run || cnt == LAST) cnt <= '0;
      else                               cnt <= cnt + 1'b1;
   end

   assign period_end = run && (cnt == LAST);
   assign sclk_lvl   = !run || (cnt >= HALF);

   // a new bit period always opens with the clock low
   assert_fall_after_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(period_end) && run) |-> !sclk_lvl);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
   import ser_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int NBYTES = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [NBYTES*BYTE_W-1:0] load_word,
   input  ser_mode_e                mode_in,
   input  logic                     period_end,
   output logic                     busy,
   output logic                     done,
   output logic                     sdata,
   output logic                     first_bit,
   output logic                     last_bit,
   output ser_mode_e                mode_q
);
   localparam int TOTAL = NBYTES * BYTE_W;
   localparam int BCW   = $clog2(TOTAL);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(TOTAL - 1);

   generate
      if (BYTE_W < 1 || NBYTES < 1 || TOTAL < 2) begin : g_bad_size
         $error("ser_shifter: transfer must hold at least two bits");
      end
   endgenerate

   logic [TOTAL-1:0] shreg;
   logic [BCW-1:0]   bit_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         shreg   <= '1;
         bit_cnt <= '0;
         mode_q  <= MODE_2W;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy    <= 1'b1;
               shreg   <= load_word;
               bit_cnt <= '0;
               mode_q  <= mode_in;
            end
         end else if (period_end) begin
            if (bit_cnt == LAST_BIT) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               shreg <= '1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
               shreg   <= {shreg[TOTAL-2:0], 1'b1};
            end
         end
      end
   end

   assign sdata     = busy ? shreg[TOTAL-1] : 1'b1;
   assign first_bit = busy && (bit_cnt == '0);
   assign last_bit  = busy && (bit_cnt == LAST_BIT);

   assert_busy_from_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mode_q));
endmodule

// File: rtl/ser_en_sel.sv
module ser_en_sel
   import ser_pkg::*;
(
   input  ser_mode_e mode,
   input  logic      busy,
   input  logic      first_bit,
   input  logic      last_bit,
   output logic      en
);
   always_comb begin
      unique case (mode)
         MODE_2W:      en = 1'b0;
         MODE_3W_FULL: en = busy;
         MODE_3W_HEAD: en = first_bit;
         MODE_3W_TAIL: en = last_bit;
         default:      en = 1'b0;
      endcase
   end
endmodule

// File: rtl/ctl_serializer.sv
module ctl_serializer
   import ser_pkg::*;
#(
   parameter int DIV    = 38,
   parameter int BYTE_W = 8,
   parameter int NPINS  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic [NPINS-1:0] ctl_out
);
   localparam int NBYTES = 3;
   localparam int TOTAL  = NBYTES * BYTE_W;

   generate
      if (NPINS != 3 || BYTE_W < 3) begin : g_bad_cfg
         $error("ctl_serializer: needs three pins and bytes of at least 3 bits");
      end
   endgenerate

   logic [NPINS-1:0]  direct_q;
   logic              own_q;
   ser_mode_e         mode_w;
   logic [BYTE_W-1:0] head_q, body_q, tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         direct_q <= '0;
         own_q    <= 1'b0;
         mode_w   <= MODE_2W;
         head_q   <= '0;
         body_q   <= '0;
         tail_q   <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADDR_DIRECT: direct_q <= wr_data[NPINS-1:0];
            ADDR_CTRL: begin
               own_q  <= wr_data[0];
               mode_w <= ser_mode_e'(wr_data[2:1]);
            end
            ADDR_HEAD: head_q <= wr_data;
            ADDR_BODY: body_q <= wr_data;
            ADDR_TAIL: tail_q <= wr_data;
            default: ;
         endcase
      end
   end

   logic            period_end, sclk_lvl, sdata, first_bit, last_bit, en;
   ser_mode_e       mode_q;
   logic [TOTAL-1:0] load_word;

   assign load_word = {head_q, body_q, tail_q};

   ser_clkdiv #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .period_end(period_end), .sclk_lvl(sclk_lvl)
   );

   ser_shifter #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .load_word(load_word),
      .mode_in(mode_w), .period_end(period_end), .busy(busy), .done(done),
      .sdata(sdata), .first_bit(first_bit), .last_bit(last_bit), .mode_q(mode_q)
   );

   ser_en_sel u_en (
      .mode(mode_q), .busy(busy), .first_bit(first_bit),
      .last_bit(last_bit), .en(en)
   );

   logic [NPINS-1:0] ser_pins;
   assign ser_pins = {en, sclk_lvl, sdata};

   genvar gi;
   generate
      for (gi = 0; gi < NPINS; gi++) begin : g_pin
         assign ctl_out[gi] = own_q ? ser_pins[gi] : direct_q[gi];
      end
   endgenerate

   assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q && !busy) |-> (ctl_out == 3'b011));
   assert_two_wire_no_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q && mode_q == MODE_2W) |-> !ctl_out[2]);
   assert_enable_inside_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q && ctl_out[2]) |-> busy);
endmodule

// File: tb/ctl_serializer_tb.sv
module ctl_serializer_tb;
   localparam int DIV   = 38;
   localparam int NBITS = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       start = 1'b0;
   logic       busy, done;
   logic [2:0] ctl_out;

   int vectors = 0;
   int errors  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ctl_serializer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .busy(busy), .done(done),
      .ctl_out(ctl_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_xfer(input logic [1:0] mode, input logic [7:0] s,
                           input logic [7:0] d, input logic [7:0] e);
      logic [23:0] word;
      word = {s, d, e};
      wr(3'd1, {5'b0, mode, 1'b1});
      wr(3'd2, s);
      wr(3'd3, d);
      wr(3'd4, e);
      chk("R10 idle lines", {5'b0, ctl_out}, 8'h03);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < NBITS * DIV; t++) begin
         int b;
         logic exp_en;
         b = t / DIV;
         case (mode)
            2'b00: exp_en = 1'b0;
            2'b01: exp_en = 1'b1;
            2'b10: exp_en = (b == 0);
            default: exp_en = (b == NBITS - 1);
         endcase
         chk("R1 sclk", {7'b0, ctl_out[1]}, {7'b0, ((t % DIV) >= DIV / 2)});
         chk("R5 R2 sdata order", {7'b0, ctl_out[0]}, {7'b0, word[NBITS-1-b]});
         if (mode == 2'b00)      chk("R6 enable low", {7'b0, ctl_out[2]}, {7'b0, exp_en});
         else if (mode == 2'b01) chk("R7 enable full", {7'b0, ctl_out[2]}, {7'b0, exp_en});
         else if (mode == 2'b10) chk("R8 enable head", {7'b0, ctl_out[2]}, {7'b0, exp_en});
         else                    chk("R9 enable tail", {7'b0, ctl_out[2]}, {7'b0, exp_en});
         chk("R10 busy", {7'b0, busy}, 8'h01);
         // R11: restart strobe and mode rewrite during transfer; R3: direct write ignored
         start   = (t == 100);
         wr_en   = (t == 200) || (t == 300);
         wr_addr = (t == 200) ? 3'd1 : 3'd0;
         wr_data = (t == 200) ? {5'b0, ~mode, 1'b1} : 8'h05;
         @(negedge clk);
      end
      start = 1'b0; wr_en = 1'b0;
      chk("R10 busy low at end", {7'b0, busy}, 8'h00);
      chk("R10 done pulse", {7'b0, done}, 8'h01);
      chk("R10 idle after xfer", {5'b0, ctl_out}, 8'h03);
      @(negedge clk);
      chk("R10 done one cycle", {7'b0, done}, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 reset outputs", {5'b0, ctl_out}, 8'h00);
      chk("R4 reset busy", {7'b0, busy}, 8'h00);
      chk("R4 reset done", {7'b0, done}, 8'h00);
      // R3: direct mode sweep
      for (int v = 0; v < 8; v++) begin
         wr(3'd0, 8'(v));
         chk("R3 direct", {5'b0, ctl_out}, 8'(v));
      end
      wr(3'd0, 8'h06);
      wr(3'd1, 8'h01);
      chk("R3 owned idle", {5'b0, ctl_out}, 8'h03);
      wr(3'd1, 8'h00);
      chk("R3 back to direct", {5'b0, ctl_out}, 8'h06);
      for (int m = 0; m < 4; m++) begin
         run_xfer(2'(m), 8'hA5, 8'h3C, 8'h81);
         run_xfer(2'(m), 8'h00, 8'hFF, 8'h5A);
      end
      // R11: mode written during last transfer applies to this one (last write was ~3 = 00)
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11 new mode used", {7'b0, ctl_out[2]}, 8'h00);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule